// File: doc/BRIEF.md
# Diagnostic Edge Event Collector

The block watches eleven single-bit diagnostic probe signals that are already synchronous to its clock. It samples each of them once per cycle and flags an edge whenever the new level differs from the previous sample in the chosen direction. Each flagged edge latches into a sticky pending bit. A per-probe enable mask decides which pending bits feed one combined, registered interrupt line. Software clears a pending bit by writing a one to it.

The lower eight probes have a programmable edge direction. The upper three always react to a rising level. A read-only view returns the sampled level of every probe, which lets firmware see the state of a probe next to its pending bit.

Access is through a plain register port with write enable, read enable, address, write data and registered read data. The word map is:

| Byte address | Register |
|---|---|
| 0x00 | Live levels (read only) |
| 0x04 | Edge direction |
| 0x08 | Enable mask |
| 0x0C | Pending (write one to clear) |

Top module: `dbg_event_collector`

## Requirements
- R1: After the synchronous active-high reset, the edge-direction, enable-mask and pending registers are 0, and both `irq_o` and `rd_data` are 0.
- R2: For a probe whose direction bit is 0, a rising level sets its pending bit, and the bit reads 1 from the cycle after the edge is sampled. A falling level sets nothing.
- R3: For probes 0 to 7, a direction bit of 1 selects falling edges: a falling level sets the pending bit and a rising level does not.
- R4: The direction register (0x04) holds only bits 0 to 7, and bits 8 to 31 read 0 whatever is written to them. Probes 8 to 10 always detect rising edges, whatever value is written to the direction register.
- R5: A pending bit stays set until a one is written to that bit position at 0x0C. Writing 0 to a bit leaves it unchanged.
- R6: If a new qualifying edge and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R7: `irq_o` is a register equal to the OR over all bits of (pending AND mask) as it stood one cycle earlier, so it trails the pending and mask registers by exactly one clock.
- R8: A pending bit whose mask bit is 0 does not raise `irq_o`.
- R9: A read of 0x00 returns the sampled probe levels in bits 0 to 10 and 0 in bits 11 to 31. Writes to 0x00 have no effect.
- R10: The first sample taken after reset never produces an edge, even if a probe is already high when reset ends.
- R11: Read data appears in `rd_data` one cycle after `rd_en` and is 0 in any cycle that follows a cycle without `rd_en`. The mask register holds bits 0 to 10, and bits 11 to 31 read 0. Any address other than the four word-aligned ones above reads 0, and writes to such an address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| probe_i | input | 11 | Diagnostic probe levels, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Byte address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| irq_o | output | 1 | Combined masked interrupt, registered |

## Verification
A probe level or register write applied before a clock edge takes effect at that edge. The pending bit is visible at the next falling edge of the clock, and `irq_o` follows one full cycle later. Read data is due one cycle after the read strobe. The scoreboard monitor records the read strobe at the rising edge and compares the popped expectation at the following falling edge. Interrupt checks are placed on the exact falling edge that these latencies give, including one check on each side of the one-cycle interrupt lag after a clear.

// File: rtl/evc_pkg.sv
package evc_pkg;
  typedef enum logic [1:0] {
    SEL_LIVE = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_MASK = 2'd2,
    SEL_PEND = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/evc_edge_detect.sv
module evc_edge_detect #(
  parameter int unsigned NUM_SIG = 11,
  parameter int unsigned NUM_SEL = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SIG-1:0] sig_in,
  input  logic [NUM_SEL-1:0] dir,
  output logic [NUM_SIG-1:0] level,
  output logic [NUM_SIG-1:0] hit
);
  logic [NUM_SIG-1:0] samp_q;
  logic               primed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      samp_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      samp_q   <= sig_in;
      primed_q <= 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_SIG; i++) begin : g_bit
    if (i < NUM_SEL) begin : g_prog
      assign hit[i] = primed_q & (dir[i] ? (samp_q[i] & ~sig_in[i])
                                         : (~samp_q[i] & sig_in[i]));
    end else begin : g_fixed
      assign hit[i] = primed_q & ~samp_q[i] & sig_in[i];
    end
  end

  assign level = samp_q;

  // R10: no edge is reported in the first cycle out of reset
  p_quiet_after_reset_r10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> hit == '0);

  // R2: an unchanged probe never produces an edge
  p_stable_no_hit_r2: assert property (@(posedge clk) disable iff (rst)
    $stable(sig_in) |-> hit == '0);
endmodule

// File: rtl/evc_regs.sv
module evc_regs
  import evc_pkg::*;
#(
  parameter int unsigned NUM_SIG = 11,
  parameter int unsigned NUM_SEL = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [DATA_W-1:0]  rd_data,
  input  logic [NUM_SIG-1:0] level,
  input  logic [NUM_SIG-1:0] hit,
  output logic [NUM_SEL-1:0] dir,
  output logic [NUM_SIG-1:0] mask,
  output logic [NUM_SIG-1:0] pend
);
  localparam int unsigned SEL_LSB = 2;
  localparam int unsigned SEL_MSB = 3;

  logic [NUM_SEL-1:0] dir_q;
  logic [NUM_SIG-1:0] mask_q;
  logic [NUM_SIG-1:0] pend_q;
  logic [NUM_SIG-1:0] clr;
  logic [DATA_W-1:0]  rd_word;
  logic [DATA_W-1:0]  rd_q;
  logic               mapped;
  reg_sel_e           sel;
  logic               unused_wdata;

  assign unused_wdata = ^wr_data[DATA_W-1:NUM_SIG];
  assign mapped = (addr[ADDR_W-1:SEL_MSB+1] == '0) && (addr[SEL_LSB-1:0] == '0);
  assign sel    = reg_sel_e'(addr[SEL_MSB:SEL_LSB]);
  assign clr    = (wr_en && mapped && sel == SEL_PEND) ? wr_data[NUM_SIG-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      mask_q <= '0;
    end else if (wr_en && mapped) begin
      if (sel == SEL_DIR)  dir_q  <= wr_data[NUM_SEL-1:0];
      if (sel == SEL_MASK) mask_q <= wr_data[NUM_SIG-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr) | hit;
  end

  always_comb begin
    rd_word = '0;
    if (mapped) begin
      case (sel)
        SEL_LIVE: rd_word[NUM_SIG-1:0] = level;
        SEL_DIR:  rd_word[NUM_SEL-1:0] = dir_q;
        SEL_MASK: rd_word[NUM_SIG-1:0] = mask_q;
        SEL_PEND: rd_word[NUM_SIG-1:0] = pend_q;
        default:  rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= rd_word;
    else            rd_q <= '0;
  end

  assign rd_data = rd_q;
  assign dir     = dir_q;
  assign mask    = mask_q;
  assign pend    = pend_q;

  // R1: registers leave reset cleared
  p_reset_clean_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pend_q == '0 && mask_q == '0 && dir_q == '0));

  // R5: a pending bit only drops where a one was written
  p_keep_pending_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (($past(pend_q) & ~$past(clr)) & ~pend_q) == '0);

  // R6: every detected edge is pending one cycle later
  p_edge_wins_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($past(hit) & ~pend_q) == '0);

  // R4: direction readback carries no bits above the programmable ones
  p_dir_pad_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_en) && $past(addr) == ADDR_W'(4)) |-> rd_data[DATA_W-1:NUM_SEL] == '0);

  // R11: no read strobe, no read data
  p_idle_read_r11: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en) |-> rd_data == '0);
endmodule

// File: rtl/evc_irq_out.sv
module evc_irq_out #(
  parameter int unsigned NUM_SIG = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SIG-1:0] pend,
  input  logic [NUM_SIG-1:0] mask,
  output logic               irq
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(pend & mask);
  end

  assign irq = irq_q;
endmodule

// File: rtl/dbg_event_collector.sv
module dbg_event_collector #(
  parameter int unsigned NUM_SIG = 11,
  parameter int unsigned NUM_SEL = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SIG-1:0] probe_i,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [DATA_W-1:0]  rd_data,
  output logic               irq_o
);
  logic [NUM_SIG-1:0] level;
  logic [NUM_SIG-1:0] hit;
  logic [NUM_SEL-1:0] dir;
  logic [NUM_SIG-1:0] mask;
  logic [NUM_SIG-1:0] pend;

  evc_edge_detect #(.NUM_SIG(NUM_SIG), .NUM_SEL(NUM_SEL)) u_edge (
    .clk(clk), .rst(rst), .sig_in(probe_i), .dir(dir), .level(level), .hit(hit)
  );

  evc_regs #(.NUM_SIG(NUM_SIG), .NUM_SEL(NUM_SEL), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .level(level), .hit(hit),
    .dir(dir), .mask(mask), .pend(pend)
  );

  evc_irq_out #(.NUM_SIG(NUM_SIG)) u_irq (
    .clk(clk), .rst(rst), .pend(pend), .mask(mask), .irq(irq_o)
  );

  // R8: with every mask bit clear the interrupt is low next cycle
  p_masked_off_r8: assert property (@(posedge clk) disable iff (rst)
    (mask == '0) |=> !irq_o);

  // R7: the interrupt only rises when something was pending
  p_irq_has_source_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(pend != '0));
endmodule

// File: tb/dbg_event_collector_tb_top.sv
`timescale 1ns/1ps
module dbg_event_collector_tb_top;
  localparam logic [5:0] A_LIVE = 6'h00;
  localparam logic [5:0] A_DIR  = 6'h04;
  localparam logic [5:0] A_MASK = 6'h08;
  localparam logic [5:0] A_PEND = 6'h0C;
  localparam logic [5:0] A_NONE = 6'h10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] probe = 11'h201;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq_o;

  always #2.5 clk = ~clk;

  dbg_event_collector dut_i (
    .clk(clk), .rst(rst), .probe_i(probe), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq_o(irq_o)
  );

  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= rd_en;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) check("R11 unexpected read", rd_data, 32'hDEAD_BEEF);
      else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_expect(input logic [5:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic set_probe(input logic [10:0] v);
    @(negedge clk);
    probe = v;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(2);
    check("R1 rd_data after reset", rd_data, 32'h0);
    check("R1 irq after reset", {31'h0, irq_o}, 32'h0);
    rd_expect(A_PEND, 32'h0, "R10 no edge from high probes at reset exit");
    rd_expect(A_DIR,  32'h0, "R1 direction reset");
    rd_expect(A_MASK, 32'h0, "R1 mask reset");
    rd_expect(A_LIVE, 32'h201, "R9 live levels");

    set_probe(11'h000); idle(2);
    rd_expect(A_PEND, 32'h0, "R2 falling ignored with direction 0");
    set_probe(11'h001); idle(2);
    rd_expect(A_PEND, 32'h1, "R2 rising sets pending");
    check("R8 masked pending no irq", {31'h0, irq_o}, 32'h0);

    wr(A_MASK, 32'h1); idle(2);
    check("R7 irq on enabled pending", {31'h0, irq_o}, 32'h1);

    wr(A_PEND, 32'h0); idle(1);
    rd_expect(A_PEND, 32'h1, "R5 write zero keeps pending");
    wr(A_PEND, 32'h1);
    check("R7 irq lags clear by one cycle", {31'h0, irq_o}, 32'h1);
    idle(1);
    check("R7 irq drops after clear", {31'h0, irq_o}, 32'h0);
    rd_expect(A_PEND, 32'h0, "R5 write one clears");

    wr(A_DIR, 32'hFFFF_FFFF);
    rd_expect(A_DIR, 32'h0000_00FF, "R4 direction width");
    set_probe(11'h003); idle(2);
    rd_expect(A_PEND, 32'h0, "R3 rising ignored with direction 1");
    set_probe(11'h001); idle(2);
    rd_expect(A_PEND, 32'h2, "R3 falling sets with direction 1");

    wr(A_PEND, 32'h7FF);
    set_probe(11'h101); idle(2);
    rd_expect(A_PEND, 32'h100, "R4 upper probe rising");
    wr(A_PEND, 32'h7FF);
    set_probe(11'h001); idle(2);
    rd_expect(A_PEND, 32'h0, "R4 upper probe falling ignored");

    wr(A_DIR, 32'h0);
    set_probe(11'h011); idle(2);
    rd_expect(A_PEND, 32'h10, "R6 setup pending");
    set_probe(11'h001); idle(2);
    @(negedge clk);
    probe = 11'h011; wr_en = 1'b1; addr = A_PEND; wr_data = 32'h10;
    @(negedge clk);
    wr_en = 1'b0;
    idle(2);
    rd_expect(A_PEND, 32'h10, "R6 edge beats clear");
    check("R8 unmasked bit not enabled", {31'h0, irq_o}, 32'h0);

    wr(A_MASK, 32'hFFFF_FFFF);
    rd_expect(A_MASK, 32'h7FF, "R11 mask width");
    check("R7 irq with full mask", {31'h0, irq_o}, 32'h1);

    wr(A_LIVE, 32'hFFFF_FFFF);
    rd_expect(A_LIVE, 32'h011, "R9 live write ignored");
    set_probe(11'h7FF); idle(2);
    rd_expect(A_LIVE, 32'h7FF, "R9 live follows probes");
    wr(A_NONE, 32'h0);
    rd_expect(A_MASK, 32'h7FF, "R11 unmapped write ignored");
    rd_expect(A_NONE, 32'h0, "R11 unmapped reads zero");
    rd_expect(6'h09, 32'h0, "R11 misaligned reads zero");
    idle(1);
    check("R11 idle read data zero", rd_data, 32'h0);

    idle(2);
    check("R11 scoreboard drained", exp_q.size(), 32'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule